// File: doc/BRIEF.md
# Dual-Mode Integer Shift and Rotate Unit

This block shifts or rotates one 32-bit data word by a 32-bit unsigned count. Five operations are available: logical left, logical right, arithmetic right, rotate left and rotate right. A run-time mode input picks how a count that does not fit in five bits is handled. In scalar mode the upper count bits are discarded and only the low five bits are used. In vector mode the full count is honoured, so an out-of-range count saturates the result.

Rotates are defined only in scalar mode. A rotate requested in vector mode, or an undefined operation code, raises an illegal-operation flag and forces the result to zero. The datapath is purely combinational. An optional output register, selected by the `REG_OUT` parameter (default 1), captures the result and flag on a clock edge where `valid_i` is high. It presents `valid_o` one cycle later.

Top module: `dual_shift_unit`

## Requirements
- R1: Scalar mode (`vec_mode_i`=0), op 000 (shift left logical): the result is data shifted left by `amt_i[4:0]`; bits `amt_i[31:5]` are ignored, so a count of 32 returns the data unchanged.
- R2: Scalar mode, op 001 (logical right) fills with zeros and op 010 (arithmetic right) fills with bit 31 of the data; both shift by `amt_i[4:0]` only.
- R3: Vector mode (`vec_mode_i`=1), op 000 or 001: the count is treated as a full unsigned 32-bit value. Any count of 32 or more gives zero, and a smaller count gives the normal shift.
- R4: Vector mode, op 010: a count of 32 or more gives every result bit equal to data bit 31; a smaller count gives the normal arithmetic shift.
- R5: Scalar mode, op 011 (rotate left) and op 100 (rotate right): the rotate amount is the count modulo 32. Bits leaving one end re-enter at the other, and an amount of 0 returns the data unchanged.
- R6: Vector mode with op 011 or 100: `illegal_o`=1 and the result is zero.
- R7: Op codes 101, 110 and 111 in either mode: `illegal_o`=1 and the result is zero. Every legal op with a legal mode gives `illegal_o`=0.
- R8: For any shift op, a count that is zero in the mode's own terms returns the data unchanged. In scalar mode that means the low five count bits are zero; in vector mode it means the whole count is zero.
- R9: With `REG_OUT`=1, result and flag are captured on a rising edge where `valid_i`=1 and appear after that edge, together with `valid_o`=1. On an edge where `valid_i`=0, `valid_o` goes to 0 and the registered result and flag hold.
- R10: While `rst_ni` is low, `result_o`, `illegal_o` and `valid_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input strobe; enables capture |
| data_i | input | 32 | Operand word |
| amt_i | input | 32 | Unsigned shift or rotate count |
| op_i | input | 3 | Operation: 000 SLL, 001 SRL, 010 SRA, 011 ROL, 100 ROR |
| vec_mode_i | input | 1 | 0 scalar (masked count), 1 vector (saturating count) |
| result_o | output | 32 | Shifted or rotated word |
| illegal_o | output | 1 | Illegal operation for the selected mode |
| valid_o | output | 1 | Result valid |

## Verification
The bench sends the same count past the 5-bit boundary in both modes. Counts of 32, 33, 36, 40 and 0x8000_0000 show whether a design masks where it should saturate, or saturates where it should mask. A design that tests only count bit 5 would miss 0x8000_0000. A wrong arithmetic fill would give zero instead of all ones for a negative operand. Rotates with wrap-around counts check that the bits leaving one end come back at the other, and that a rotate in vector mode is flagged rather than computed. Register hold and reset are also checked at the ports, so a design that captured without `valid_i` would show a changed result.

// File: rtl/dsu_pkg.sv
package dsu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SLL = 3'd0,
    OP_SRL = 3'd1,
    OP_SRA = 3'd2,
    OP_ROL = 3'd3,
    OP_ROR = 3'd4
  } op_e;
endpackage

// File: rtl/dsu_decode.sv
module dsu_decode #(
  parameter int unsigned AMT_W  = 32,
  parameter int unsigned STEP_W = 5
) (
  input  logic [dsu_pkg::OP_W-1:0] op_i,
  input  logic                     vec_mode_i,
  input  logic [AMT_W-1:0]         amt_i,
  output logic [STEP_W-1:0]        step_o,
  output logic                     sat_o,
  output logic                     illegal_o
);
  import dsu_pkg::*;

  logic over, is_rot, code_ok;

  assign step_o  = amt_i[STEP_W-1:0];
  assign over    = |amt_i[AMT_W-1:STEP_W];
  assign is_rot  = (op_i == OP_ROL) || (op_i == OP_ROR);
  assign code_ok = (op_i <= OP_ROR);

  assign illegal_o = !code_ok || (vec_mode_i && is_rot);
  // saturation only for legal shifts in vector mode
  assign sat_o     = vec_mode_i && over && code_ok && !is_rot;

  always_comb begin
    if (!vec_mode_i) AST_SCALAR_NO_SAT: assert (!sat_o); // R1
  end
endmodule

// File: rtl/dsu_barrel.sv
module dsu_barrel #(
  parameter int unsigned W      = 32,
  parameter int unsigned STEP_W = 5
) (
  input  logic [W-1:0]             data_i,
  input  logic [dsu_pkg::OP_W-1:0] op_i,
  input  logic [STEP_W-1:0]        step_i,
  output logic [W-1:0]             data_o
);
  import dsu_pkg::*;

  logic         sign;
  logic [W-1:0] stg [STEP_W+1];

  assign sign   = data_i[W-1];
  assign stg[0] = data_i;

  for (genvar k = 0; k < STEP_W; k++) begin : g_stage
    localparam int unsigned SH = 1 << k;
    logic [W-1:0] cur, sll_v, srl_v, sra_v, rol_v, ror_v;

    assign cur   = stg[k];
    assign sll_v = cur << SH;
    assign srl_v = cur >> SH;
    assign sra_v = {{SH{sign}}, cur[W-1:SH]};
    assign rol_v = {cur[W-1-SH:0], cur[W-1:W-SH]};
    assign ror_v = {cur[SH-1:0], cur[W-1:SH]};

    assign stg[k+1] = !step_i[k]       ? cur   :
                      (op_i == OP_SLL) ? sll_v :
                      (op_i == OP_SRL) ? srl_v :
                      (op_i == OP_SRA) ? sra_v :
                      (op_i == OP_ROL) ? rol_v :
                      (op_i == OP_ROR) ? ror_v : cur;
  end

  assign data_o = stg[STEP_W];

  always_comb begin
    if (step_i == '0) AST_ZERO_STEP_PASS: assert (data_o == data_i); // R8
  end
endmodule

// File: rtl/dsu_outreg.sv
module dsu_outreg #(
  parameter int unsigned W       = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] res_i,
  input  logic         ill_i,
  output logic [W-1:0] res_o,
  output logic         ill_o,
  output logic         valid_o
);
  if (REG_OUT) begin : g_reg
    logic [W-1:0] res_q;
    logic         ill_q, vld_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_q <= '0;
        ill_q <= 1'b0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= valid_i;
        if (valid_i) begin
          res_q <= res_i;
          ill_q <= ill_i;
        end
      end
    end

    assign res_o   = res_q;
    assign ill_o   = ill_q;
    assign valid_o = vld_q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> (!valid_o && $stable(res_o) && $stable(ill_o))); // R9
    AST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> (res_o == $past(res_i))); // R9
  end else begin : g_comb
    assign res_o   = res_i;
    assign ill_o   = ill_i;
    assign valid_o = valid_i;
  end
endmodule

// File: rtl/dual_shift_unit.sv
module dual_shift_unit #(
  parameter int unsigned W       = dsu_pkg::DATA_W,
  parameter int unsigned AMT_W   = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [W-1:0]             data_i,
  input  logic [AMT_W-1:0]         amt_i,
  input  logic [dsu_pkg::OP_W-1:0] op_i,
  input  logic                     vec_mode_i,
  output logic [W-1:0]             result_o,
  output logic                     illegal_o,
  output logic                     valid_o
);
  import dsu_pkg::*;

  localparam int unsigned STEP_W = $clog2(W);

  logic [STEP_W-1:0] step;
  logic              sat, ill;
  logic [W-1:0]      shifted, sat_val, res;

  dsu_decode #(.AMT_W(AMT_W), .STEP_W(STEP_W)) u_decode (
    .op_i       (op_i),
    .vec_mode_i (vec_mode_i),
    .amt_i      (amt_i),
    .step_o     (step),
    .sat_o      (sat),
    .illegal_o  (ill)
  );

  dsu_barrel #(.W(W), .STEP_W(STEP_W)) u_barrel (
    .data_i (data_i),
    .op_i   (op_i),
    .step_i (step),
    .data_o (shifted)
  );

  // saturated value: sign fill for SRA, zero otherwise
  assign sat_val = (op_i == OP_SRA) ? {W{data_i[W-1]}} : '0;
  assign res     = ill ? '0 : (sat ? sat_val : shifted);

  dsu_outreg #(.W(W), .REG_OUT(REG_OUT)) u_outreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .res_i   (res),
    .ill_i   (ill),
    .res_o   (result_o),
    .ill_o   (illegal_o),
    .valid_o (valid_o)
  );

  always_comb begin
    if (ill) AST_ILLEGAL_ZERO: assert (res == '0); // R7
    if (vec_mode_i && (op_i == OP_ROL || op_i == OP_ROR))
      AST_VEC_ROT_ILLEGAL: assert (ill); // R6
    if (vec_mode_i && amt_i >= AMT_W'(W) && (op_i == OP_SLL || op_i == OP_SRL))
      AST_VEC_SAT_ZERO: assert (res == '0); // R3
    if (vec_mode_i && amt_i >= AMT_W'(W) && op_i == OP_SRA)
      AST_VEC_SRA_FILL: assert (res == {W{data_i[W-1]}}); // R4
  end
endmodule

// File: tb/dual_shift_unit_tb_top.sv
module dual_shift_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 25;

  typedef struct packed {
    logic [15:0] tag;
    logic [2:0]  op;
    logic        vec;
    logic [31:0] d;
    logic [31:0] a;
    logic [31:0] e;
    logic        ill;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{"R1", 3'd0, 1'b0, 32'h1234_5678, 32'd4,          32'h2345_6780, 1'b0},
    '{"R1", 3'd0, 1'b0, 32'h1234_5678, 32'd36,         32'h2345_6780, 1'b0},
    '{"R1", 3'd0, 1'b0, 32'h1234_5678, 32'd32,         32'h1234_5678, 1'b0},
    '{"R2", 3'd1, 1'b0, 32'h8000_0001, 32'd1,          32'h4000_0000, 1'b0},
    '{"R2", 3'd2, 1'b0, 32'h8000_0001, 32'd1,          32'hC000_0000, 1'b0},
    '{"R2", 3'd2, 1'b0, 32'h8000_0001, 32'd33,         32'hC000_0000, 1'b0},
    '{"R2", 3'd1, 1'b0, 32'h8000_0001, 32'hFFFF_FFFF,  32'h0000_0001, 1'b0},
    '{"R2", 3'd2, 1'b0, 32'h8000_0001, 32'd31,         32'hFFFF_FFFF, 1'b0},
    '{"R3", 3'd0, 1'b1, 32'h1234_5678, 32'd32,         32'h0000_0000, 1'b0},
    '{"R3", 3'd1, 1'b1, 32'h1234_5678, 32'h8000_0000,  32'h0000_0000, 1'b0},
    '{"R3", 3'd0, 1'b1, 32'h1234_5678, 32'd4,          32'h2345_6780, 1'b0},
    '{"R4", 3'd2, 1'b1, 32'h8000_0001, 32'd40,         32'hFFFF_FFFF, 1'b0},
    '{"R4", 3'd2, 1'b1, 32'h7000_000F, 32'd100,        32'h0000_0000, 1'b0},
    '{"R4", 3'd2, 1'b1, 32'h8000_0001, 32'd4,          32'hF800_0000, 1'b0},
    '{"R5", 3'd3, 1'b0, 32'h8000_0001, 32'd1,          32'h0000_0003, 1'b0},
    '{"R5", 3'd4, 1'b0, 32'h8000_0001, 32'd1,          32'hC000_0000, 1'b0},
    '{"R5", 3'd3, 1'b0, 32'h1234_5678, 32'd36,         32'h2345_6781, 1'b0},
    '{"R5", 3'd4, 1'b0, 32'h1234_5678, 32'd8,          32'h7812_3456, 1'b0},
    '{"R5", 3'd3, 1'b0, 32'h1234_5678, 32'd32,         32'h1234_5678, 1'b0},
    '{"R6", 3'd3, 1'b1, 32'h1234_5678, 32'd1,          32'h0000_0000, 1'b1},
    '{"R6", 3'd4, 1'b1, 32'h1234_5678, 32'd0,          32'h0000_0000, 1'b1},
    '{"R7", 3'd5, 1'b0, 32'h1234_5678, 32'd1,          32'h0000_0000, 1'b1},
    '{"R7", 3'd7, 1'b1, 32'h1234_5678, 32'd0,          32'h0000_0000, 1'b1},
    '{"R8", 3'd2, 1'b1, 32'h7000_000F, 32'd0,          32'h7000_000F, 1'b0},
    '{"R8", 3'd1, 1'b0, 32'h1234_5678, 32'd0,          32'h1234_5678, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [31:0] amt_i = '0;
  logic [2:0]  op_i = '0;
  logic        vec_mode_i = 1'b0;
  logic [31:0] result_o;
  logic        illegal_o, valid_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_shift_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .amt_i(amt_i), .op_i(op_i), .vec_mode_i(vec_mode_i),
    .result_o(result_o), .illegal_o(illegal_o), .valid_o(valid_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic vec,
                       input logic [31:0] d, input logic [31:0] a, input logic v);
    op_i = op; vec_mode_i = vec; data_i = d; amt_i = a; valid_i = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "result_o in reset", result_o, 32'h0);
    chk("R10", "illegal_o in reset", {31'b0, illegal_o}, 32'h0);
    chk("R10", "valid_o in reset", {31'b0, valid_o}, 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i].op, TBL[i].vec, TBL[i].d, TBL[i].a, 1'b1);
      @(negedge clk);
      chk(string'(TBL[i].tag), $sformatf("vec %0d result", i), result_o, TBL[i].e);
      chk(string'(TBL[i].tag), $sformatf("vec %0d illegal", i),
          {31'b0, illegal_o}, {31'b0, TBL[i].ill});
      chk("R9", $sformatf("vec %0d valid_o", i), {31'b0, valid_o}, 32'h1);
    end

    // R9: hold while valid_i low (last capture was 0x1234_5678, legal)
    @(negedge clk);
    drive(3'd5, 1'b1, 32'hDEAD_BEEF, 32'd3, 1'b0);
    @(negedge clk);
    chk("R9", "result held when idle", result_o, 32'h1234_5678);
    chk("R9", "illegal held when idle", {31'b0, illegal_o}, 32'h0);
    chk("R9", "valid_o low when idle", {31'b0, valid_o}, 32'h0);

    // R9: capture resumes
    drive(3'd0, 1'b0, 32'h0000_00FF, 32'd8, 1'b1);
    @(negedge clk);
    chk("R9", "capture after idle", result_o, 32'h0000_FF00);
    chk("R9", "valid_o after idle", {31'b0, valid_o}, 32'h1);

    // R10: asynchronous reset mid-run clears outputs
    drive(3'd7, 1'b0, 32'h1, 32'd0, 1'b1);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R10", "result cleared by reset", result_o, 32'h0);
    chk("R10", "illegal cleared by reset", {31'b0, illegal_o}, 32'h0);
    chk("R10", "valid cleared by reset", {31'b0, valid_o}, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    valid_i = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule